// File: doc/BRIEF.md
# DRAM Bank Row-Access Sequencer

This block controls a single DRAM bank of 1024 rows, each row holding eight 256-bit column words. Each access to a new row goes through four timed steps. First the bit lines are precharged. Then the sense amplifiers read the row out. Then the cells are written back (restore). Only after that is the column word read. The duration of each step is a cycle count supplied on configuration inputs. After a row has been sensed it stays open, so later requests to that row pay only the column time.

With the row-buffer option enabled, the sensed row is held in a buffer. While columns are still being served from the buffered row, the bank can precharge, sense and restore the next row. Only one such next row can be in progress at a time. A request to a further row waits at the request port until the buffered row is released.

Requests arrive with a row and column-word address under a valid/ready handshake. Responses come back in request order as a one-cycle valid strobe with a 256-bit word. The storage array is behavioural and read-only. Its contents are a fixed function of the address, so a client can recognise every word it receives.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and no row is open. The first request therefore takes the full miss latency of R3, even when it addresses row 0.
- R2: A row access runs precharge, sense, restore and then the column step, in that fixed order. Each step lasts the number of cycles on its configuration input, and a programmed count of 0 behaves as 1.
- R3: With both engines idle, a request to a row that is not open raises `resp_valid` Tp+Ts+Tr+Tc+2 clock edges after the edge that accepted it.
- R4: A request to the open row skips every row step and raises `resp_valid` Tc+1 edges after its accept edge. A row that a miss has opened stays open for later requests.
- R5: The response word consists of eight 32-bit lanes. Lane k occupies bits [32k+31:32k] and holds {16-bit row, 8-bit column, 8-bit k}.
- R6: Each accepted request produces exactly one `resp_valid` pulse of one cycle. Responses are returned in the order the requests were accepted.
- R7: At most one request waits at the port. `req_ready` is 0 in the cycle after an accept and stays 0 until the waiting request has started its column step.
- R8: With the row buffer off, precharge of a new row does not begin until the current column access ends. A miss accepted one edge after the previous column access was launched therefore completes Tp+Ts+Tr+2·Tc edges after its accept.
- R9: With the row buffer on, the next row's precharge, sense and restore overlap the current column access. The same miss then completes after max(Tp+Ts+Tr+Tc+2, 2·Tc) edges.
- R10: With the row buffer on, a request to a third row is accepted only one edge after the buffered row's waiting request starts its column step. With three back-to-back misses, the third is accepted Tp+Ts+Tr+3 edges after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_t_pre | input | 4 | Precharge cycles (Tp) |
| cfg_t_sense | input | 4 | Sense readout cycles (Ts) |
| cfg_t_restore | input | 4 | Restore cycles (Tr) |
| cfg_t_col | input | 4 | Column access cycles (Tc) |
| cfg_rowbuf | input | 1 | 1 enables next-row overlap through the row buffer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_row | input | 10 | Row address |
| req_col | input | 3 | Column-word address within the row |
| resp_valid | output | 1 | One-cycle strobe marking a returned word |
| resp_data | output | 256 | Returned column word |

## Verification
Every latency is counted in clock edges from the edge that accepted the request to the edge after which `resp_valid` is high. A hit takes Tc+1 edges and an isolated miss takes Tp+Ts+Tr+Tc+2. A miss queued behind a column access takes Tp+Ts+Tr+2·Tc when the buffer is off, and max(Tp+Ts+Tr+Tc+2, 2·Tc) when it is on. The driver samples `req_ready` on the falling edge and records the next rising edge as the accept edge. The monitor samples `resp_valid` on falling edges and subtracts the two edge numbers. Each directed latency check is therefore exact to the cycle, and every returned word is compared in order against the lane pattern computed from its address.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

    localparam int BANK_ROWS     = 1024;
    localparam int BANK_BITCOLS  = 2048;
    localparam int WORD_W        = 256;
    localparam int WORDS_PER_ROW = BANK_BITCOLS / WORD_W;
    localparam int ROW_W         = $clog2(BANK_ROWS);
    localparam int COL_W         = $clog2(WORDS_PER_ROW);
    localparam int LANE_W        = 32;
    localparam int LANES         = WORD_W / LANE_W;
    localparam int TIME_W        = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SENSE,
        PH_RESTORE,
        PH_HELD
    } row_phase_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } bank_addr_t;

    // A programmed count of zero still occupies one cycle.
    function automatic logic [TIME_W-1:0] eff_cycles(input logic [TIME_W-1:0] n);
        return (n == '0) ? TIME_W'(1) : n;
    endfunction

endpackage

// File: rtl/dram_bank_array.sv
module dram_bank_array
    import dram_bank_pkg::*;
(
    input  bank_addr_t          addr,
    output logic [WORD_W-1:0]   word
);

    // Read-only behavioural contents: every lane tags its own address.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word[k*LANE_W +: LANE_W] = {16'(addr.row), 8'(addr.col), 8'(k)};
    end

endmodule

// File: rtl/dram_bank_row_eng.sv
module dram_bank_row_eng
    import dram_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ROW_W-1:0]   start_row,
    input  logic               col_free,
    input  logic [TIME_W-1:0]  t_pre,
    input  logic [TIME_W-1:0]  t_sense,
    input  logic [TIME_W-1:0]  t_restore,
    output row_phase_e         phase,
    output logic [ROW_W-1:0]   tgt_row,
    output logic               swap
);

    logic [TIME_W-1:0] cnt;
    logic              cnt_last;

    assign cnt_last = (cnt == TIME_W'(1));

    // The freshly restored row replaces the open row once columns are idle.
    assign swap = ((phase == PH_RESTORE) && cnt_last && col_free) ||
                  ((phase == PH_HELD) && col_free);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            tgt_row <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_PRE;
                        cnt     <= eff_cycles(t_pre);
                        tgt_row <= start_row;
                    end
                end
                PH_PRE: begin
                    if (cnt_last) begin
                        phase <= PH_SENSE;
                        cnt   <= eff_cycles(t_sense);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SENSE: begin
                    if (cnt_last) begin
                        phase <= PH_RESTORE;
                        cnt   <= eff_cycles(t_restore);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RESTORE: begin
                    if (cnt_last) begin
                        phase <= col_free ? PH_IDLE : PH_HELD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HELD: begin
                    if (col_free) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dram_bank_col_eng.sv
module dram_bank_col_eng
    import dram_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  bank_addr_t         launch_addr,
    input  logic [TIME_W-1:0]  t_col,
    input  logic [WORD_W-1:0]  rd_word,
    output logic               busy,
    output logic               free,
    output bank_addr_t         cur_addr,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_data
);

    logic [TIME_W-1:0] cnt;
    logic              last;

    assign last = busy && (cnt == TIME_W'(1));
    assign free = !busy || last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cnt        <= '0;
            cur_addr   <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= last;
            if (last) begin
                resp_data <= rd_word;
            end
            if (launch) begin
                busy     <= 1'b1;
                cnt      <= eff_cycles(t_col);
                cur_addr <= launch_addr;
            end else if (last) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dram_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [TIME_W-1:0]  cfg_t_pre,
    input  logic [TIME_W-1:0]  cfg_t_sense,
    input  logic [TIME_W-1:0]  cfg_t_restore,
    input  logic [TIME_W-1:0]  cfg_t_col,
    input  logic               cfg_rowbuf,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_data
);

    logic               pend_vld;
    bank_addr_t         pend_addr;
    logic               open_vld;
    logic [ROW_W-1:0]   open_row;
    logic               pend_hit;
    logic               col_launch;
    logic               row_start;
    logic               col_busy;
    logic               col_free;
    bank_addr_t         col_addr;
    logic [WORD_W-1:0]  arr_word;
    row_phase_e         row_phase;
    logic [ROW_W-1:0]   row_tgt;
    logic               row_swap;

    assign req_ready  = !pend_vld;
    assign pend_hit   = pend_vld && open_vld && (pend_addr.row == open_row);
    assign col_launch = pend_hit && col_free;
    // Without the buffer the sense amps must finish serving columns first.
    assign row_start  = pend_vld && !pend_hit && (row_phase == PH_IDLE) &&
                        (cfg_rowbuf || col_free);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            open_vld  <= 1'b0;
            open_row  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                pend_vld  <= 1'b1;
                pend_addr <= '{row: req_row, col: req_col};
            end else if (col_launch) begin
                pend_vld <= 1'b0;
            end
            if (row_swap) begin
                open_vld <= 1'b1;
                open_row <= row_tgt;
            end else if (row_start && !cfg_rowbuf) begin
                open_vld <= 1'b0;
            end
        end
    end

    dram_bank_row_eng u_row (
        .clk       (clk),
        .rst       (rst),
        .start     (row_start),
        .start_row (pend_addr.row),
        .col_free  (col_free),
        .t_pre     (cfg_t_pre),
        .t_sense   (cfg_t_sense),
        .t_restore (cfg_t_restore),
        .phase     (row_phase),
        .tgt_row   (row_tgt),
        .swap      (row_swap)
    );

    dram_bank_col_eng u_col (
        .clk         (clk),
        .rst         (rst),
        .launch      (col_launch),
        .launch_addr (pend_addr),
        .t_col       (cfg_t_col),
        .rd_word     (arr_word),
        .busy        (col_busy),
        .free        (col_free),
        .cur_addr    (col_addr),
        .resp_valid  (resp_valid),
        .resp_data   (resp_data)
    );

    dram_bank_array u_arr (
        .addr (col_addr),
        .word (arr_word)
    );

endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk
    import dram_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_ready,
    input  logic        resp_valid,
    input  logic [7:0]  lane0_tag,
    input  logic [7:0]  lane1_tag,
    input  logic        cfg_rowbuf,
    input  row_phase_e  row_phase,
    input  logic        col_busy
);

    logic [1:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 2'(req_valid && req_ready) - 2'(resp_valid);
        end
    end

    AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (inflight != 2'd0)); // R6

    AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (rst)
        inflight <= 2'd2); // R7

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (row_phase == PH_IDLE) |=> (row_phase inside {PH_IDLE, PH_PRE})); // R2

    AST_PRE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (row_phase == PH_PRE) |=> (row_phase inside {PH_PRE, PH_SENSE})); // R2

    AST_SENSE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (row_phase == PH_SENSE) |=> (row_phase inside {PH_SENSE, PH_RESTORE})); // R2

    AST_RESTORE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (row_phase == PH_RESTORE) |=> (row_phase inside {PH_RESTORE, PH_IDLE, PH_HELD})); // R2

    AST_NO_OVERLAP_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rowbuf && (row_phase inside {PH_PRE, PH_SENSE, PH_RESTORE})) |-> !col_busy); // R8

    AST_HELD_WAITS_COL: assert property (@(posedge clk) disable iff (rst)
        (row_phase == PH_HELD) |-> col_busy); // R9

    AST_LANE_TAGS: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((lane0_tag == 8'd0) && (lane1_tag == 8'd1))); // R5

endmodule

bind dram_bank_seq dram_bank_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .lane0_tag  (resp_data[7:0]),
    .lane1_tag  (resp_data[39:32]),
    .cfg_rowbuf (cfg_rowbuf),
    .row_phase  (row_phase),
    .col_busy   (col_busy)
);

// File: tb/dram_bank_seq_bench.sv
module dram_bank_seq_bench;
    import dram_bank_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [TIME_W-1:0]  cfg_t_pre = 4'd2;
    logic [TIME_W-1:0]  cfg_t_sense = 4'd2;
    logic [TIME_W-1:0]  cfg_t_restore = 4'd3;
    logic [TIME_W-1:0]  cfg_t_col = 4'd1;
    logic               cfg_rowbuf = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [ROW_W-1:0]   req_row = '0;
    logic [COL_W-1:0]   req_col = '0;
    logic               resp_valid;
    logic [WORD_W-1:0]  resp_data;

    int total = 0;
    int bad = 0;
    int edge_no = 0;
    int resp_cnt = 0;
    int issued = 0;
    int lat [0:255];
    logic [WORD_W-1:0] exp_q [$];
    int acc_q [$];

    always #10 clk = ~clk;
    always @(posedge clk) edge_no <= edge_no + 1;

    dram_bank_seq u_dram_bank_seq (
        .clk           (clk),
        .rst           (rst),
        .cfg_t_pre     (cfg_t_pre),
        .cfg_t_sense   (cfg_t_sense),
        .cfg_t_restore (cfg_t_restore),
        .cfg_t_col     (cfg_t_col),
        .cfg_rowbuf    (cfg_rowbuf),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_row       (req_row),
        .req_col       (req_col),
        .resp_valid    (resp_valid),
        .resp_data     (resp_data)
    );

    function automatic logic [WORD_W-1:0] exp_word(input int row, input int col);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < LANES; k++) begin
            w[k*LANE_W +: LANE_W] = {16'(row), 8'(col), 8'(k)};
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int row, input int col, output int acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        while (!req_ready) @(negedge clk);
        acc = edge_no + 1;
        exp_q.push_back(exp_word(row, col));
        acc_q.push_back(acc);
        issued++;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_resp(input int n);
        while (resp_cnt < n) @(negedge clk);
    endtask

    // Scoreboard monitor: order, data and latency of every response.
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6 response without request actual=1 expected=0");
            end else begin
                logic [WORD_W-1:0] e;
                int a;
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                if (resp_data !== e) begin
                    bad++;
                    $display("FAIL R5 word actual=%h expected=%h", resp_data, e);
                end
                lat[resp_cnt] = edge_no - a;
                resp_cnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", resp_cnt, issued);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int a, b, c;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);

        // R1: row 0 is not open after reset, full miss latency 2+2+3+1+2
        issue(0, 0, a); wait_resp(1);
        chk(lat[0] == 10, "R1 first request misses", lat[0], 10);
        // R4: hit on the open row
        issue(0, 3, a); wait_resp(2);
        chk(lat[1] == 2, "R4 hit latency", lat[1], 2);
        // R3: miss to a new row
        issue(7, 5, a); wait_resp(3);
        chk(lat[2] == 10, "R3 miss latency", lat[2], 10);
        // R7: ready drops after an accept
        issue(7, 1, a);
        @(negedge clk);
        chk(req_ready == 1'b0, "R7 ready low with waiting request", int'(req_ready), 0);
        wait_resp(4);
        chk(lat[3] == 2, "R4 row kept open", lat[3], 2);

        // R8: buffer off, Tc=6, second miss waits for first column access
        cfg_t_col = 4'd6;
        issue(20, 0, a); issue(21, 2, b); wait_resp(6);
        chk(lat[4] == 15, "R3 miss latency Tc=6", lat[4], 15);
        chk(lat[5] == 19, "R8 no overlap without buffer", lat[5], 19);

        // R9: buffer on, next row phases overlap column access
        cfg_rowbuf = 1'b1;
        issue(22, 1, a); issue(23, 4, b); wait_resp(8);
        chk(lat[7] == 15, "R9 overlapped miss", lat[7], 15);

        // R10: a third row waits until the buffered row is released
        issue(40, 0, a); issue(41, 0, b); issue(42, 0, c); wait_resp(11);
        chk(c - b == 10, "R10 third row accept spacing", c - b, 10);
        chk(lat[10] == 15, "R10 third row latency", lat[10], 15);

        // R9: restore finishes before the long column access ends
        cfg_t_col = 4'd12;
        issue(50, 3, a); issue(51, 7, b); wait_resp(13);
        chk(lat[12] == 24, "R9 held row waits for column", lat[12], 24);

        // R2: zero counts behave as one cycle
        cfg_rowbuf = 1'b0;
        cfg_t_pre = 4'd0; cfg_t_sense = 4'd0; cfg_t_restore = 4'd0; cfg_t_col = 4'd0;
        issue(60, 2, a); wait_resp(14);
        chk(lat[13] == 6, "R2 zero counts miss", lat[13], 6);
        issue(60, 6, a); wait_resp(15);
        chk(lat[14] == 2, "R2 zero count hit", lat[14], 2);

        // R5/R6: mixed streams in both modes, scoreboard checks order and data
        cfg_t_pre = 4'd2; cfg_t_sense = 4'd2; cfg_t_restore = 4'd3; cfg_t_col = 4'd2;
        for (int m = 0; m < 2; m++) begin
            cfg_rowbuf = m[0];
            for (int i = 0; i < 24; i++) begin
                issue(100 + ((i * 5 + m) % 3) + ((i % 7 == 0) ? 900 : 0), (i * 3) % 8, a);
            end
            wait_resp(issued);
        end

        repeat (20) @(negedge clk);
        chk(resp_cnt == issued, "R6 one response per request", resp_cnt, issued);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule